// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block is the digital back end of a parallel analog-to-digital converter. A bank of 2^N-1 comparators, each against its own reference at k/2^N of full scale (k = 1 .. 2^N-1), presents a thermometer pattern on a plain input vector. The block turns that pattern into an N-bit binary code and stores it in an output register.

The code is the number of comparator inputs that are high. An ideal thermometer pattern therefore maps to its level. A non-monotonic ("bubble") pattern still yields a defined code, and one isolated bubble moves the result by at most one LSB.

A one-cycle sample strobe captures the code together with an overrange flag, which copies the top comparator. A valid output pulses on the clock after each strobe. Nothing is presented combinationally.

Top module: `flash_therm_enc`

## Requirements
- R1: Synchronous active-high reset clears `code_q`, `over_q` and `valid_q` to 0 at the next rising edge, even when `sample` is high in that cycle.
- R2: At a rising edge with `sample` high, `code_q` takes the number of bits of `comp` that are 1, as an unsigned N-bit value.
- R3: A `comp` of all zeros is captured as code 0 (lowest range).
- R4: A `comp` of all ones is captured as code 2^N-1, all bits 1 (top range).
- R5: A non-monotonic `comp`, for example 7'b1011011 with N=3, is captured as its count of ones (5 in that example), and does not follow the position of the highest 1.
- R6: At a rising edge with `sample` low, `code_q` and `over_q` keep their values, whatever `comp` does.
- R7: `valid_q` is 1 in the cycle after each edge with `sample` high and 0 after each edge with `sample` low. Strobes on consecutive cycles hold it high.
- R8: At a capture edge, `over_q` takes `comp[2^N-2]`, the top comparator, which is bit 6 for N=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 1 | Capture strobe for the current comparator pattern |
| comp | input | 2^N-1 | Comparator outputs; bit k-1 is the comparator at k/2^N of full scale |
| code_q | output | N | Registered binary code |
| over_q | output | 1 | Registered overrange flag (top comparator) |
| valid_q | output | 1 | Pulses one cycle after each strobe |

## Verification
Every result is due exactly one rising edge after the strobe that requested it. `code_q`, `over_q` and `valid_q` all change at that edge.

The driver sets `comp` and `sample` on a falling edge and queues the expected code and flag. The monitor samples on the following falling edges. Whenever it sees `valid_q` high, it pops the oldest queued item, so each comparison lands half a cycle after the edge that produced the result.

The hold and reset checks read the outputs on the falling edge after the edge in question.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  // number of comparator taps for an N-bit code
  function automatic int unsigned tap_count(input int unsigned n);
    return (1 << n) - 1;
  endfunction

  // index of the comparator sitting nearest full scale
  function automatic int unsigned top_tap(input int unsigned n);
    return (1 << n) - 2;
  endfunction
endpackage

// File: rtl/therm_count.sv
module therm_count #(
  parameter int unsigned N = 3,
  localparam int unsigned L = ftc_pkg::tap_count(N)
) (
  input  logic [L-1:0] taps,
  output logic [N-1:0] level,
  output logic         top_hit
);
  logic [N-1:0] part [L];

  assign part[0] = N'(taps[0]);

  generate
    for (genvar i = 1; i < L; i++) begin : g_acc
      assign part[i] = part[i-1] + N'(taps[i]);
    end
  endgenerate

  assign level   = part[L-1];
  assign top_hit = taps[ftc_pkg::top_tap(N)];

  always_comb begin
    if (taps == '0) a_zero_r3: assert (level == '0);
    if (&taps)      a_full_r4: assert (&level);
  end
endmodule

// File: rtl/therm_capture.sv
module therm_capture #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [N-1:0] level_in,
  input  logic         top_in,
  output logic [N-1:0] code_q,
  output logic         over_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      over_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) begin
        code_q <= level_in;
        over_q <= top_in;
      end
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (code_q == '0 && !over_q && !valid_q));

  p_capture_level_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> code_q == $past(level_in));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(code_q) && $stable(over_q)));

  p_valid_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> valid_q);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> !valid_q);

  p_over_top_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> over_q == $past(top_in));
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc #(
  parameter int unsigned N = 3,
  localparam int unsigned L = ftc_pkg::tap_count(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic [L-1:0] comp,
  output logic [N-1:0] code_q,
  output logic         over_q,
  output logic         valid_q
);
  logic [N-1:0] ev_level;
  logic         ev_top;
  logic         ev_take;

  assign ev_take = sample;

  therm_count #(.N(N)) count_i (
    .taps    (comp),
    .level   (ev_level),
    .top_hit (ev_top)
  );

  therm_capture #(.N(N)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .take     (ev_take),
    .level_in (ev_level),
    .top_in   (ev_top),
    .code_q   (code_q),
    .over_q   (over_q),
    .valid_q  (valid_q)
  );

  p_full_code_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_take && (&comp)) |=> (&code_q && over_q));
endmodule

// File: tb/flash_therm_enc_tb_top.sv
`timescale 1ns/1ps
module flash_therm_enc_tb_top;
  localparam int N = 3;
  localparam int L = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sample = 1'b0;
  logic [L-1:0] comp = '0;
  logic [N-1:0] code_q;
  logic         over_q;
  logic         valid_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [N:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  flash_therm_enc #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .sample(sample), .comp(comp),
    .code_q(code_q), .over_q(over_q), .valid_q(valid_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N:0] model(input logic [L-1:0] v);
    int c = 0;
    for (int i = 0; i < L; i++) if (v[i]) c++;
    return {v[L-1], c[N-1:0]};
  endfunction

  // driver: one strobe per call, optionally keep strobe for next call
  task automatic drive(input logic [L-1:0] v, input string req, input bit keep);
    comp   = v;
    sample = 1'b1;
    exp_q.push_back(model(v));
    tag_q.push_back(req);
    @(negedge clk);
    if (!keep) sample = 1'b0;
  endtask

  // monitor: scoreboard pop on each valid
  always @(negedge clk) begin
    #0.5;
    if (!rst && !done && valid_q) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 spurious valid", 1, 0);
      end else begin
        logic [N:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(code_q == e[N-1:0], t, code_q, e[N-1:0]);
        chk(over_q == e[N], {"R8 ", t}, over_q, e[N]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    chk(code_q == 0 && !over_q && !valid_q, "R1 reset state", code_q, 0);
    rst = 1'b0;
    @(negedge clk);

    drive(7'b0000000, "R3 all low", 1'b0);
    drive(7'b1111111, "R4 all high", 1'b0);
    for (int k = 0; k <= L; k++) begin
      logic [L-1:0] t;
      t = (7'b1 << k) - 7'b1;
      if (k == L) t = '1;
      drive(t, "R2 thermometer level", 1'b0);
    end
    drive(7'b1011011, "R5 bubble high", 1'b0);
    drive(7'b0000101, "R5 bubble low", 1'b0);
    drive(7'b1000000, "R5 lone top", 1'b0);
    // back-to-back strobes
    drive(7'b0000011, "R7 back-to-back a", 1'b1);
    drive(7'b0011111, "R7 back-to-back b", 1'b1);
    drive(7'b0111111, "R7 back-to-back c", 1'b0);
    #0.5;
    chk(valid_q == 1'b1, "R7 valid after last strobe", valid_q, 1);
    @(negedge clk); #0.5;
    chk(valid_q == 1'b0, "R7 valid drops", valid_q, 0);
    chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);

    // hold while idle
    held = code_q;
    comp = 7'b1111111;
    repeat (3) @(negedge clk);
    #0.5;
    chk(code_q == held, "R6 code holds", code_q, held);
    chk(over_q == 1'b0, "R6 over holds", over_q, 0);
    chk(valid_q == 1'b0, "R6 no valid", valid_q, 0);

    // reset wins over strobe
    drive(7'b1111111, "R4 before reset", 1'b0);
    @(negedge clk);
    rst = 1'b1;
    sample = 1'b1;
    @(negedge clk); #0.5;
    chk(code_q == 0 && !over_q && !valid_q, "R1 reset over strobe", code_q, 0);
    sample = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    done = 1'b1;
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule